// File: doc/BRIEF.md
# Log-Depth Prefix Carry Adder

This block adds two unsigned WIDTH-bit words and a carry-in. It is purely combinational: there is no clock and no stored state. No carry ripples from one bit to the next. Each bit first forms its own generate (both operand bits set) and propagate (operand bits differ). A tree of combine levels then doubles the span of every group at each step, 1, 2, 4 and so on. After log2(WIDTH) levels, each position holds the generate and propagate of the whole range from itself down to bit 0.

The carry-in is merged into those full-range terms after the last level. This gives the carry into every bit in one step. Each sum bit is its propagate XOR its incoming carry. The carry-out is the carry leaving the top bit. WIDTH must be a power of two from 4 to 64, and any other value stops elaboration. The block suits any datapath that needs a wide add with short, predictable depth.

Top module: `prefix_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout, sum} equals a + b + cin taken modulo 2^(WIDTH+1).
- R2: With both operands zero, sum equals cin in bit 0 and zero elsewhere, and cout is 0.
- R3: When a and b are bitwise complements, every bit propagates. With cin = 0, sum is all ones and cout is 0. With cin = 1, sum is all zeros and cout is 1.
- R4: When bit WIDTH-1 of both a and b is 1, cout is 1 whatever the other bits are.
- R5: When bit WIDTH-1 of both a and b is 0, cout is 0 whatever the other bits are.
- R6: With both operands all ones, cout is 1. Sum is all ones in bits WIDTH-1 down to 1, and bit 0 equals cin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The bench builds the adder with WIDTH = 32. That gives five combine levels, and the last level joins 16-bit groups. Carries generated in the lowest bits must therefore cross every level before they reach cout. Directed patterns place a single generate at bit 0 under an otherwise fully propagating word, and they hold all-ones and complement operands. These cases make each group span and the carry-in merge decide the result. Random operands with both carry-in values cover the general case.

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int LEVELS = $clog2(WIDTH);

  generate
    if ((WIDTH & (WIDTH - 1)) != 0 || WIDTH < 4 || WIDTH > 64) begin : g_bad_width
      $error("prefix_adder: WIDTH must be a power of two in 4..64");
    end
  endgenerate

  wire [WIDTH-1:0] gen  [0:LEVELS];
  wire [WIDTH-1:0] prop [0:LEVELS];
  wire [WIDTH:0]   carry;

  assign gen[0]  = a & b;
  assign prop[0] = a ^ b;

  generate
    for (genvar k = 0; k < LEVELS; k++) begin : g_level
      localparam int SPAN = 1 << k;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= SPAN) begin : g_join
          assign gen[k+1][i]  = gen[k][i] | (prop[k][i] & gen[k][i-SPAN]);
          assign prop[k+1][i] = prop[k][i] & prop[k][i-SPAN];
        end else begin : g_pass
          assign gen[k+1][i]  = gen[k][i];
          assign prop[k+1][i] = prop[k][i];
        end
      end
    end
  endgenerate

  assign carry[0] = cin;
  assign carry[WIDTH:1] = gen[LEVELS] | (prop[LEVELS] & {WIDTH{cin}});

  assign sum  = prop[0] ^ carry[WIDTH-1:0];
  assign cout = carry[WIDTH];
endmodule

// File: rtl/prefix_adder_chk.sv
module prefix_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    p_total_r1: assert ({cout, sum} == ref_total);
    if (a == '0 && b == '0)
      p_zero_ops_r2: assert (sum == {{(WIDTH-1){1'b0}}, cin} && !cout);
    if ((a ^ b) == '1)
      p_full_prop_r3: assert (sum == {WIDTH{~cin}} && cout == cin);
    if (a[WIDTH-1] && b[WIDTH-1])
      p_top_gen_r4: assert (cout);
    if (!a[WIDTH-1] && !b[WIDTH-1])
      p_top_kill_r5: assert (!cout);
    if (a == '1 && b == '1)
      p_all_ones_r6: assert (cout && sum == {{(WIDTH-1){1'b1}}, cin});
  end
endmodule

bind prefix_adder prefix_adder_chk #(.WIDTH(WIDTH)) u_prefix_adder_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
);

// File: tb/test_prefix_adder.sv
module test_prefix_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic cin, cout;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefix_adder #(.WIDTH(W)) i_prefix_adder (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci,
                       input string req);
    logic [W:0] exp_v;
    @(negedge clk);
    a = x; b = y; cin = ci;
    #1;
    exp_v = ref_add(x, y, ci);
    n_tests++;
    if ({cout, sum} !== exp_v) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h",
               req, x, y, ci, {cout, sum}, exp_v);
    end
  endtask

  task automatic check_cout(input logic exp_c, input string req);
    n_tests++;
    if (cout !== exp_c) begin
      n_fail++;
      $display("FAIL %s cout actual=%0d expected=%0d", req, cout, exp_c);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    void'($urandom(32'd20240611));

    apply('0, '0, 1'b0, "R2");
    apply('0, '0, 1'b1, "R2");
    apply(32'hA5A5_0F0F, ~32'hA5A5_0F0F, 1'b0, "R3");
    apply(32'hA5A5_0F0F, ~32'hA5A5_0F0F, 1'b1, "R3");
    apply(32'hFFFF_FFFE, 32'h0000_0001, 1'b1, "R3");
    apply('1, '1, 1'b0, "R6");
    apply('1, '1, 1'b1, "R6");
    apply('1, 32'h1, 1'b0, "R1");
    apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R1");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R4");
    check_cout(1'b1, "R4");
    apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b1, "R5");
    check_cout(1'b0, "R5");
    apply(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R1");
    apply(32'hFFFF_0000, 32'h0001_0000, 1'b0, "R1");

    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x, y;
      x = $urandom();
      y = $urandom();
      if (i % 4 == 1) y = ~x;
      if (i % 8 == 3) begin x[W-1] = 1'b1; y[W-1] = 1'b1; end
      if (i % 8 == 5) begin x[W-1] = 1'b0; y[W-1] = 1'b0; end
      apply(x, y, 1'($urandom() & 1), "R1");
      if (i % 8 == 3) check_cout(1'b1, "R4");
      if (i % 8 == 5) check_cout(1'b0, "R5");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule